// File: doc/BRIEF.md
# Serial-In Parallel-Out FIFO Buffer

This block is a first-in, first-out word store whose write side receives data one bit at a time and whose read side returns complete words in parallel. A serial clock input and a serial data input feed a bit assembler. A mode input sets the word length to 8 or 9 bits. When the selected number of bits has arrived, the assembled word is committed into a storage array. A read strobe, active low, removes the oldest word onto a 9-bit bus. An output-enable input gates that bus, and the gating is reported on an enable output in place of a tri-state pad.

Everything runs on one system clock. The serial clock and the read strobe are sampled as ordinary inputs, and their edges are found by comparing each sample with the one before. Four status flags report the fill level: empty, almost-empty, half-full and full. When the store is full, a completed word is held back. Serial bits that arrive while that word is waiting are thrown away, and a sticky loss indication records the event. The depth must be a power of two, with 2048 or 4096 words in use.

Top module: `sipo_fifo`

## Requirements
- R1: A serial bit is taken only on a low-to-high transition of `ser_clk`; holding `ser_clk` high for several system clocks takes exactly one bit.
- R2: The first serial bit of a word appears on `q[0]`, the second on `q[1]`, and so on.
- R3: With `len9`=1 a word is 9 serial bits. With `len9`=0 a word is 8 serial bits and `q[8]` reads 0.
- R4: `word_done` goes high once the selected bit count has been received and stays high until the word is committed. If the store is not full, the word is committed on the next clock.
- R5: While `full` is high no word is committed. A waiting word is committed as soon as a read frees a location, and it is read after all older words.
- R6: Serial bits that arrive while a completed word is waiting are discarded, and `data_lost` goes high and stays high until reset.
- R7: A read happens on a high-to-low transition of `rd_n` and only when `empty` is low; a strobe while empty changes nothing.
- R8: Words are read in the order they were written, independent of ongoing writes.
- R9: `q_en` is high only when `rd_n` is low and `oe` is high; while `q_en` is low, `q` is all zeros.
- R10: With N stored words, `empty`=(N==0), `full`=(N==DEPTH), `almost_empty`=(N<=AE_LEVEL) and `half_full`=(N>DEPTH/2).
- R11: Reset (`rst_n` low) empties the store, clears the bit counter, `word_done` and `data_lost`, sets `empty` and `almost_empty`, and clears `half_full` and `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock, sampled; a rising transition takes one bit |
| ser_din | input | 1 | Serial data bit |
| len9 | input | 1 | Word length select: 1 = 9 bits, 0 = 8 bits |
| rd_n | input | 1 | Read strobe, active low; a falling transition reads one word |
| oe | input | 1 | Output enable while `rd_n` is low |
| q | output | 9 | Read data, zero when not enabled |
| q_en | output | 1 | High when `q` is being driven |
| word_done | output | 1 | A completed serial word is waiting to be committed |
| data_lost | output | 1 | Sticky: serial bits were discarded |
| empty | output | 1 | No words stored |
| almost_empty | output | 1 | Stored count at or below AE_LEVEL |
| half_full | output | 1 | Stored count above half the depth |
| full | output | 1 | All DEPTH locations in use |

## Verification
The hardest case to reach is a completed word held back by a full store while more serial bits keep arriving. To get there, the bench builds the block with a small depth and fills it with serial words. It sends one more complete word, which must then wait with `word_done` high, and follows it with one extra serial bit, which must be lost. A single read must then let the waiting word into the store, so `full` returns. The bench drains the store and confirms that the waiting word comes out after all the older words.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t      shreg;
        logic [3:0] cnt;
        logic       pend;
        logic       lost;
        logic       sclk_prev;
    } asm_state_t;
endpackage

// File: rtl/sipo_assembler.sv
module sipo_assembler
    import sipo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ser_clk,
    input  logic  ser_din,
    input  logic  len9,
    input  logic  full_i,
    output logic  push_o,
    output word_t word_o,
    output logic  word_done_o,
    output logic  lost_o
);
    asm_state_t s_d, s_q;
    logic       edge_w;
    logic [3:0] last_w;

    always_comb begin
        logic [3:0] cnt_v;
        logic       pend_v;
        s_d    = s_q;
        edge_w = ser_clk & ~s_q.sclk_prev;
        last_w = len9 ? 4'd8 : 4'd7;
        push_o = s_q.pend & ~full_i;
        cnt_v  = s_q.cnt;
        pend_v = s_q.pend;
        s_d.sclk_prev = ser_clk;
        if (push_o) begin
            pend_v = 1'b0;
            cnt_v  = '0;
        end
        if (edge_w) begin
            if (pend_v) begin
                s_d.lost = 1'b1;
            end else begin
                s_d.shreg[cnt_v] = ser_din;
                if (cnt_v >= last_w) pend_v = 1'b1;
                else                 cnt_v  = cnt_v + 4'd1;
            end
        end
        s_d.cnt  = cnt_v;
        s_d.pend = pend_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o      = len9 ? s_q.shreg : {1'b0, s_q.shreg[7:0]};
    assign word_done_o = s_q.pend;
    assign lost_o      = s_q.lost;

    // R6: loss may only start while a finished word waits
    a_r6_loss_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.lost) |-> $past(s_q.pend));
    // R6: loss indication is sticky
    a_r6_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lost |=> s_q.lost);
endmodule

// File: rtl/sipo_store.sv
module sipo_store
    import sipo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  word_t         wdata_i,
    input  logic          rd_n,
    output word_t         rdata_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        word_t         dout;
        logic          rd_prev;
    } st_t;

    st_t   s_d, s_q;
    word_t mem [DEPTH];
    logic  pop;

    always_comb begin
        s_d = s_q;
        s_d.rd_prev = rd_n;
        pop = ~rd_n & s_q.rd_prev & (s_q.count != '0);
        if (push_i) s_d.wptr = s_q.wptr + AW'(1);
        if (pop) begin
            s_d.rptr = s_q.rptr + AW'(1);
            s_d.dout = mem[s_q.rptr];
        end
        case ({push_i, pop})
            2'b10:   s_d.count = s_q.count + CW'(1);
            2'b01:   s_d.count = s_q.count - CW'(1);
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            s_q.rd_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[s_q.wptr] <= wdata_i;
    end

    assign rdata_o = s_q.dout;
    assign count_o = s_q.count;

    // R5: the assembler never commits into a full store
    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> s_q.count != CW'(DEPTH));
    // R10: occupancy never exceeds the depth
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));
    // R8: a lone write grows the occupancy by one
    a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop) |=> s_q.count == $past(s_q.count) + CW'(1));
endmodule

// File: rtl/sipo_flags.sv
module sipo_flags #(
    parameter int DEPTH    = 2048,
    parameter int AE_LEVEL = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count_i,
    output logic          empty,
    output logic          almost_empty,
    output logic          half_full,
    output logic          full
);
    always_comb begin
        empty        = (count_i == '0);
        full         = (count_i == CW'(DEPTH));
        almost_empty = (count_i <= CW'(AE_LEVEL));
        half_full    = (count_i >  CW'(DEPTH / 2));
    end
endmodule

// File: rtl/sipo_fifo.sv
module sipo_fifo
    import sipo_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter int AE_LEVEL = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_din,
    input  logic        len9,
    input  logic        rd_n,
    input  logic        oe,
    output logic [8:0]  q,
    output logic        q_en,
    output logic        word_done,
    output logic        data_lost,
    output logic        empty,
    output logic        almost_empty,
    output logic        half_full,
    output logic        full
);
    logic          push;
    word_t         wword, rword;
    logic [CW-1:0] count;

    sipo_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .len9(len9), .full_i(full), .push_o(push), .word_o(wword),
        .word_done_o(word_done), .lost_o(data_lost)
    );

    sipo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(wword),
        .rd_n(rd_n), .rdata_o(rword), .count_o(count)
    );

    sipo_flags #(.DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL)) u_flags (
        .count_i(count), .empty(empty), .almost_empty(almost_empty),
        .half_full(half_full), .full(full)
    );

    always_comb begin
        q_en = ~rd_n & oe;
        q    = q_en ? rword : '0;
    end

    // R9: a disabled bus carries zeros
    a_r9_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |-> q == '0);
    // R10: flags are mutually consistent
    a_r10_flag_consistency: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (almost_empty && !half_full && !full));
endmodule

// File: tb/sim_sipo_fifo.sv
`timescale 1ns/1ps
module sim_sipo_fifo;
    localparam int DEPTH = 16;
    localparam int AEL   = 3;

    logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, len9 = 1, rd_n = 1, oe = 0;
    logic [8:0] q;
    logic q_en, word_done, data_lost, empty, almost_empty, half_full, full;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sipo_fifo #(.DEPTH(DEPTH), .AE_LEVEL(AEL)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .len9(len9),
        .rd_n(rd_n), .oe(oe), .q(q), .q_en(q_en), .word_done(word_done),
        .data_lost(data_lost), .empty(empty), .almost_empty(almost_empty),
        .half_full(half_full), .full(full)
    );

    // {len9, serial data, expected q}
    localparam logic [18:0] VEC [6] = '{
        {1'b1, 9'h1A5, 9'h1A5}, {1'b0, 9'h1FF, 9'h0FF}, {1'b1, 9'h001, 9'h001},
        {1'b0, 9'h180, 9'h080}, {1'b1, 9'h100, 9'h100}, {1'b0, 9'h055, 9'h055}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [8:0] d, input bit nine, input int hold);
        len9 = nine;
        for (int b = 0; b < (nine ? 9 : 8); b++) begin
            @(negedge clk); ser_din = d[b]; ser_clk = 1;
            repeat (hold) @(negedge clk);
            ser_clk = 0;
        end
        @(negedge clk);
    endtask

    task automatic read_word(input logic [8:0] exp, input string req);
        @(negedge clk); rd_n = 0; oe = 0;
        @(negedge clk);
        chk(q_en == 0 && q == 0, "R9 oe low", {q_en, q}, 0);
        oe = 1; #1;
        chk(q_en == 1, "R9 enabled", q_en, 1);
        chk(q == exp, req, q, exp);
        @(negedge clk); rd_n = 1; #1;
        chk(q_en == 0 && q == 0, "R9 strobe high", {q_en, q}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] xw;
        repeat (3) @(negedge clk);
        chk(empty && almost_empty && !half_full && !full, "R11 reset flags",
            {empty, almost_empty, half_full, full}, 4'b1100);
        chk(!word_done && !data_lost && !q_en, "R11 reset status", {word_done, data_lost, q_en}, 0);
        rst_n = 1;
        @(negedge clk);

        // table: R1 (held serial clock), R2, R3, R8
        for (int i = 0; i < 6; i++) send_word(VEC[i][17:9], VEC[i][18], (i == 2) ? 4 : 1);
        chk(!empty && !almost_empty && !word_done, "R10 six stored", {empty, almost_empty}, 0);
        for (int i = 0; i < 6; i++) read_word(VEC[i][8:0], "R2 R3 R8 R1 table word");
        chk(empty == 1, "R10 empty after drain", empty, 1);

        // R7: strobe while empty does nothing
        @(negedge clk); rd_n = 0; @(negedge clk); rd_n = 1; @(negedge clk);
        chk(empty == 1, "R7 empty strobe", empty, 1);
        send_word(9'h0C3, 1, 1);
        read_word(9'h0C3, "R7 pointer unchanged");

        // fill: R10 thresholds, R4 word_done pulse
        for (int i = 0; i < DEPTH; i++) begin
            send_word(9'(i * 37 + 5), 1, 1);
            chk(word_done == 0, "R4 committed", word_done, 0);
            if (i + 1 == AEL)       chk(almost_empty == 1, "R10 ae at level", almost_empty, 1);
            if (i + 1 == AEL + 1)   chk(almost_empty == 0, "R10 ae above", almost_empty, 0);
            if (i + 1 == DEPTH / 2) chk(half_full == 0, "R10 hf at half", half_full, 0);
            if (i + 1 == DEPTH / 2 + 1) chk(half_full == 1, "R10 hf above", half_full, 1);
            if (i + 1 == DEPTH - 1) chk(full == 0, "R10 not full", full, 0);
        end
        chk(full == 1, "R10 full", full, 1);

        // R5 / R4 / R6: a word blocked by full
        xw = 9'h1B6;
        send_word(xw, 1, 1);
        chk(word_done == 1 && full == 1, "R5 word held", {word_done, full}, 2'b11);
        chk(data_lost == 0, "R6 no loss yet", data_lost, 0);
        @(negedge clk); ser_din = 1; ser_clk = 1; @(negedge clk); ser_clk = 0; @(negedge clk);
        chk(data_lost == 1, "R6 loss flagged", data_lost, 1);
        read_word(9'(5), "R8 first after full");
        chk(full == 1 && word_done == 0, "R5 pending committed", {full, word_done}, 2'b10);
        for (int i = 1; i < DEPTH; i++) read_word(9'(i * 37 + 5), "R8 drain order");
        read_word(xw, "R5 held word last");
        chk(empty == 1 && data_lost == 1, "R6 loss sticky", {empty, data_lost}, 2'b11);

        // R11: reset clears loss and partial word
        @(negedge clk); ser_din = 1; ser_clk = 1; @(negedge clk); ser_clk = 0;
        rst_n = 0; @(negedge clk);
        chk(data_lost == 0 && empty == 1, "R11 reset clears", {data_lost, empty}, 1);
        rst_n = 1; @(negedge clk);
        send_word(9'h0A6, 0, 1);
        read_word(9'h0A6, "R11 bit counter cleared");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule